// File: doc/BRIEF.md
# Cascadable Synchronous Binary Counter

This block is a four-bit binary up-counter that advances modulo sixteen on the rising clock edge. Four control inputs choose what happens at each edge. An active-low clear has the highest priority. An active-low load comes next. Counting follows when both enables are high, and the counter holds its value otherwise. Of the two enables, `cep` only gates counting. `cet` gates counting and also the terminal-count output `tc`. This difference is what lets several stages be chained into one wide synchronous counter.

The top level chains a parameterised number of these stages into one wide counter. A carry-lookahead network drives each upper stage's enables. The low stage's "at maximum" condition reaches every upper stage's parallel enable. The trickle enable of each upper stage follows the terminal count of the stage below it. So a higher stage advances only on the edge where every lower stage rolls over. Clear and load reach all stages at the same time. The top-level `tc` is the terminal count of the highest stage.

Top module: `casc_counter`

## Requirements
- R1: A stage counts in binary modulo sixteen. State 15 (4'b1111) followed by a count edge gives state 0. The chained counter counts modulo 2^(STAGES*WIDTH) in the same way. With the defaults, 12'hFFF goes to 12'h000.
- R2: When `mr_n` is low at a rising edge, `q` becomes all zeros after that edge, whatever `pe_n`, `cep`, `cet` and `p` are.
- R3: When `mr_n` is high and `pe_n` is low at a rising edge, `q` takes the value of `p` after that edge, whatever `cep` and `cet` are.
- R4: When `mr_n` and `pe_n` are both high, the counter increments by one only if `cep` and `cet` are both high. If either is low, `q` keeps its value.
- R5: `tc` is high exactly when `cet` is high and `q` is all ones. `cep` has no effect on it. A change on `cet` reaches `tc` in the same cycle, with no clock edge needed.
- R6: `q` changes only at rising clock edges. A change on any control or data input between edges leaves `q` as it was until the next rising edge.
- R7: In the chain, stage k (k > 0) advances only on an edge where the chain is counting and every stage below k holds all ones. When the external `cep` is low, no stage advances, even if the low stage is at its maximum.
- R8: In the chain, clear and load act on every stage at the same edge. Load takes the full `p` word.
- R9: The chain's `tc` is high only when the whole word is all ones and `cet` is high. Over one full count cycle of 2^(STAGES*WIDTH) edges, starting from zero, it is high for exactly one cycle, and the word returns to zero.
- R10: Every stage holds zero from the start of operation, before any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. All state changes happen on its rising edge |
| mr_n | input | 1 | Synchronous clear, active low, highest priority |
| pe_n | input | 1 | Synchronous parallel load, active low |
| cep | input | 1 | Parallel count enable. Gates counting only |
| cet | input | 1 | Trickle count enable. Gates counting and terminal count |
| p | input | STAGES*WIDTH | Load data, stage 0 in the low bits |
| q | output | STAGES*WIDTH | Counter value, stage 0 in the low bits |
| tc | output | 1 | Terminal count of the chain: `cet` high and `q` all ones |

## Verification
The bench goes after several priority corner cases.
- Clear together with load must clear. A design with the priority swapped would load instead.
- Load with both enables low must still load. A design that gates load with the enables would hold.
- A `cep` that is low while the stage sits at 15 must leave `tc` high. A design that folds `cep` into `tc` would drop it.

In the chain, the low stage is parked at its maximum with `cep` low. A lookahead network that ignores the external `cep` would advance the upper stages there. A mid-cycle change on `cet` or `mr_n` checks two more faults: a registered `tc` that lags by one cycle, and an asynchronous clear. A full 4096-edge sweep finally counts the `tc` pulses. A carry that fires early or twice would show up there as an extra pulse.

// File: rtl/ctr_pkg.sv
// Package: shared types for the cascadable counter.
// Assumes: nothing; holds only the operating-mode encoding.
package ctr_pkg;

    // Operating mode of one stage for the coming rising edge, in priority order.
    typedef enum logic [1:0] {
        MODE_CLEAR = 2'd0,
        MODE_LOAD  = 2'd1,
        MODE_COUNT = 2'd2,
        MODE_HOLD  = 2'd3
    } ctr_mode_e;

endpackage

// File: rtl/ctr_mode_decode.sv
// Module: ctr_mode_decode
// Turns the four control inputs of one stage into a single mode value,
// applying the fixed priority clear > load > count > hold.
// Assumes: the inputs are synchronous to the stage clock; purely combinational.
module ctr_mode_decode
    import ctr_pkg::*;
(
    input  logic      mr_n,
    input  logic      pe_n,
    input  logic      cep,
    input  logic      cet,
    output ctr_mode_e mode
);

    // Priority selection of the edge action.
    always_comb begin
        if (!mr_n) begin
            mode = MODE_CLEAR;
        end else if (!pe_n) begin
            mode = MODE_LOAD;
        end else if (cep && cet) begin
            mode = MODE_COUNT;
        end else begin
            mode = MODE_HOLD;
        end
    end

endmodule

// File: rtl/ctr_stage.sv
// Module: ctr_stage
// One WIDTH-bit binary up-counter with synchronous active-low clear,
// synchronous active-low load, two count enables and a terminal-count
// output qualified by the trickle enable only.
// Assumes: WIDTH >= 1; the register starts at zero at the beginning of operation.
module ctr_stage
    import ctr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             mr_n,
    input  logic             pe_n,
    input  logic             cep,
    input  logic             cet,
    input  logic [WIDTH-1:0] p,
    output logic [WIDTH-1:0] q,
    output logic             tc
);

    localparam logic [WIDTH-1:0] MAX_VAL = {WIDTH{1'b1}};

    ctr_mode_e        mode;
    logic [WIDTH-1:0] q_r       = '0;
    logic [WIDTH-1:0] q_nxt;
    logic             started_r = 1'b0;

    ctr_mode_decode u_decode (
        .mr_n (mr_n),
        .pe_n (pe_n),
        .cep  (cep),
        .cet  (cet),
        .mode (mode)
    );

    // Next-state selection for the chosen mode.
    always_comb begin
        unique case (mode)
            MODE_CLEAR: q_nxt = '0;
            MODE_LOAD:  q_nxt = p;
            MODE_COUNT: q_nxt = q_r + 1'b1;
            default:    q_nxt = q_r;
        endcase
    end

    // Counter register, updated only on the rising edge.
    always_ff @(posedge clk) begin
        q_r <= q_nxt;
    end

    // Marks that at least one edge has passed, so the checks below can look back.
    always_ff @(posedge clk) begin
        started_r <= 1'b1;
    end

    // Outputs: state and trickle-qualified terminal count.
    always_comb begin
        q  = q_r;
        tc = cet && (q_r == MAX_VAL);
    end

    assert_clear_R2: assert property (@(posedge clk) disable iff (!started_r)
        !mr_n |=> (q == '0));

    assert_load_R3: assert property (@(posedge clk) disable iff (!started_r)
        (mr_n && !pe_n) |=> (q == $past(p)));

    assert_count_R4: assert property (@(posedge clk) disable iff (!started_r)
        (mr_n && pe_n && cep && cet) |=> (q == $past(q) + 1'b1));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!started_r)
        (mr_n && pe_n && !(cep && cet)) |=> $stable(q));

    assert_wrap_R1: assert property (@(posedge clk) disable iff (!started_r)
        (mr_n && pe_n && cep && cet && (q == MAX_VAL)) |=> (q == '0));

endmodule

// File: rtl/ctr_lookahead.sv
// Module: ctr_lookahead
// Enable network for a chain of counter stages. Stage 0 takes the external
// enables. Every upper stage's parallel enable is the external cep ANDed with
// stage 0's terminal condition. Its trickle enable is the terminal condition of
// the stage just below it, built as a lookahead AND from the stage
// "all ones" flags rather than by threading outputs back through the stages.
// Assumes: STAGES >= 1; at_max[i] is high when stage i holds all ones.
module ctr_lookahead #(
    parameter int STAGES = 3
) (
    input  logic              cep,
    input  logic              cet,
    input  logic [STAGES-1:0] at_max,
    output logic [STAGES-1:0] cep_v,
    output logic [STAGES-1:0] cet_v
);

    // Lowest stage sees the external enables unchanged.
    always_comb begin
        cep_v[0] = cep;
        cet_v[0] = cet;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_upper
        // Trickle enable of stage i: external cet and all lower stages at maximum.
        always_comb begin
            cet_v[i] = cet && (&at_max[i-1:0]);
        end
        // Parallel enable of stage i: external cep and stage 0's terminal count.
        always_comb begin
            cep_v[i] = cep && cet && at_max[0];
        end
    end

endmodule

// File: rtl/casc_counter.sv
// Module: casc_counter
// STAGES counter stages of WIDTH bits chained by a carry-lookahead enable
// network into one wide synchronous binary counter. Clear and load are shared
// by all stages; tc is the terminal count of the highest stage.
// Assumes: STAGES >= 1, WIDTH >= 1; stage 0 occupies the low bits of p and q.
module casc_counter #(
    parameter int STAGES = 3,
    parameter int WIDTH  = 4
) (
    input  logic                    clk,
    input  logic                    mr_n,
    input  logic                    pe_n,
    input  logic                    cep,
    input  logic                    cet,
    input  logic [STAGES*WIDTH-1:0] p,
    output logic [STAGES*WIDTH-1:0] q,
    output logic                    tc
);

    localparam int TOTAL_W = STAGES * WIDTH;
    localparam logic [TOTAL_W-1:0] TOTAL_MAX = {TOTAL_W{1'b1}};
    localparam logic [WIDTH-1:0]   STAGE_MAX = {WIDTH{1'b1}};

    logic [STAGES-1:0]  at_max;
    logic [STAGES-1:0]  cep_v;
    logic [STAGES-1:0]  cet_v;
    logic [STAGES-1:0]  stage_tc;
    logic [TOTAL_W-1:0] q_w;
    logic               started_r = 1'b0;

    ctr_lookahead #(.STAGES(STAGES)) u_lookahead (
        .cep    (cep),
        .cet    (cet),
        .at_max (at_max),
        .cep_v  (cep_v),
        .cet_v  (cet_v)
    );

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        ctr_stage #(.WIDTH(WIDTH)) u_stage (
            .clk  (clk),
            .mr_n (mr_n),
            .pe_n (pe_n),
            .cep  (cep_v[i]),
            .cet  (cet_v[i]),
            .p    (p[i*WIDTH +: WIDTH]),
            .q    (q_w[i*WIDTH +: WIDTH]),
            .tc   (stage_tc[i])
        );
        // Per-stage maximum flag feeding the lookahead network.
        always_comb begin
            at_max[i] = (q_w[i*WIDTH +: WIDTH] == STAGE_MAX);
        end
    end

    // Chain outputs: full word and the top stage's terminal count.
    always_comb begin
        q  = q_w;
        tc = stage_tc[STAGES-1];
    end

    // Marks that at least one edge has passed, for the checks below.
    always_ff @(posedge clk) begin
        started_r <= 1'b1;
    end

    for (genvar i = 0; i + 1 < STAGES; i++) begin : g_chk
        assert_lookahead_R7: assert property (@(posedge clk) disable iff (!started_r)
            stage_tc[i] == cet_v[i+1]);
    end

    assert_chain_step_R7: assert property (@(posedge clk) disable iff (!started_r)
        (mr_n && pe_n && cep && cet) |=> (q == $past(q) + 1'b1));

    assert_chain_hold_R7: assert property (@(posedge clk) disable iff (!started_r)
        (mr_n && pe_n && !(cep && cet)) |=> $stable(q));

    assert_chain_load_R8: assert property (@(posedge clk) disable iff (!started_r)
        (mr_n && !pe_n) |=> (q == $past(p)));

    assert_chain_tc_R9: assert property (@(posedge clk) disable iff (!started_r)
        tc |-> (cet && (q == TOTAL_MAX)));

endmodule

// File: tb/tb_casc_counter.sv
// Testbench for casc_counter (three stages) and a lone ctr_stage.
module tb_casc_counter;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 16;

    // Vector: {mr_n, pe_n, cep, cet, p[3:0], exp_q[3:0], exp_tc}
    localparam logic [12:0] VEC [NVEC] = '{
        13'b0_1_1_1_0000_0000_0, // R2 clear
        13'b1_1_1_1_0000_0001_0, // R4 count
        13'b1_1_0_1_0000_0001_0, // R4 hold, cep low
        13'b1_1_1_0_0000_0001_0, // R4 hold, cet low
        13'b1_0_0_0_1110_1110_0, // R3 load with enables low
        13'b1_1_1_1_0000_1111_1, // R4 count to 15, R5 tc
        13'b1_1_0_1_0000_1111_1, // R5 cep has no effect on tc
        13'b1_1_1_0_0000_1111_0, // R5 cet low drops tc
        13'b1_1_1_1_0000_0000_0, // R1 wrap
        13'b1_0_1_1_1111_1111_1, // R3 load 15
        13'b0_0_1_1_0101_0000_0, // R2 clear beats load
        13'b1_0_1_1_1001_1001_0, // R3 load 9
        13'b0_1_1_1_0000_0000_0, // R2 clear
        13'b1_0_0_1_0011_0011_0, // R3 load 3
        13'b1_1_1_1_0000_0100_0, // R4 count
        13'b1_1_0_0_0000_0100_0  // R4 hold
    };

    logic        clk = 1'b0;
    // chain signals
    logic        mr_n = 1'b1, pe_n = 1'b1, cep = 1'b0, cet = 1'b0;
    logic [11:0] p = '0;
    logic [11:0] q;
    logic        tc;
    // lone stage signals
    logic        s_mr_n = 1'b1, s_pe_n = 1'b1, s_cep = 1'b0, s_cet = 1'b0;
    logic [3:0]  s_p = '0;
    logic [3:0]  s_q;
    logic        s_tc;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    casc_counter #(.STAGES(3), .WIDTH(4)) dut (
        .clk(clk), .mr_n(mr_n), .pe_n(pe_n), .cep(cep), .cet(cet),
        .p(p), .q(q), .tc(tc)
    );

    ctr_stage #(.WIDTH(4)) dut_one (
        .clk(clk), .mr_n(s_mr_n), .pe_n(s_pe_n), .cep(s_cep), .cet(s_cet),
        .p(s_p), .q(s_q), .tc(s_tc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    // Reference models, written from the requirements.
    function automatic logic [3:0] ref4(logic m, logic l, logic ep, logic et, logic [3:0] d, logic [3:0] cur);
        if (!m) return 4'h0;
        if (!l) return d;
        if (ep && et) return cur + 4'h1;
        return cur;
    endfunction

    function automatic logic [11:0] ref12(logic m, logic l, logic ep, logic et, logic [11:0] d, logic [11:0] cur);
        if (!m) return 12'h000;
        if (!l) return d;
        if (ep && et) return cur + 12'h001;
        return cur;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [3:0]  m1;
        logic [11:0] m3;
        int          tc_hits;

        // R10: both counters start at zero before any edge.
        #1;
        check("R10 stage power-up q", {28'd0, s_q}, 32'h0);
        check("R10 chain power-up q", {20'd0, q}, 32'h0);
        @(negedge clk);

        // Vector table on the lone stage.
        for (int i = 0; i < NVEC; i++) begin
            {s_mr_n, s_pe_n, s_cep, s_cet, s_p} = VEC[i][12:5];
            step();
            check("R1-table q", {28'd0, s_q}, {28'd0, VEC[i][4:1]});
            check("R5 table tc", {31'd0, s_tc}, {31'd0, VEC[i][0]});
        end
        m1 = 4'h4;

        // R6: mid-cycle clear does not act before the edge.
        s_mr_n = 1'b0;
        #1;
        check("R6 no async clear", {28'd0, s_q}, 32'h4);
        step();
        check("R2 clear at edge", {28'd0, s_q}, 32'h0);

        // R5: tc follows cet within the cycle.
        s_mr_n = 1'b1; s_pe_n = 1'b0; s_p = 4'hF; s_cet = 1'b1; s_cep = 1'b0;
        step();
        check("R5 tc at 15", {31'd0, s_tc}, 32'h1);
        s_cet = 1'b0;
        #1;
        check("R5 tc drops with cet same cycle", {31'd0, s_tc}, 32'h0);
        s_cet = 1'b1;
        #1;
        check("R5 tc rises with cet same cycle", {31'd0, s_tc}, 32'h1);
        s_pe_n = 1'b1;
        step();
        m1 = 4'hF;

        // Random control sequences on the lone stage (R1 R2 R3 R4 R5).
        for (int i = 0; i < 1500; i++) begin
            s_mr_n = ($urandom % 16) != 0;
            s_pe_n = ($urandom % 8) != 0;
            s_cep  = ($urandom % 4) != 0;
            s_cet  = ($urandom % 4) != 0;
            s_p    = 4'($urandom);
            m1 = ref4(s_mr_n, s_pe_n, s_cep, s_cet, s_p, m1);
            step();
            check("R4 random stage q", {28'd0, s_q}, {28'd0, m1});
            check("R5 random stage tc", {31'd0, s_tc}, {31'd0, s_cet && (m1 == 4'hF)});
        end

        // Chain: R7 lookahead respects external cep.
        mr_n = 1'b1; pe_n = 1'b0; p = 12'h0FF; cep = 1'b0; cet = 1'b1;
        step();
        check("R8 chain load", {20'd0, q}, 32'h0FF);
        pe_n = 1'b1;
        step();
        check("R7 no upper advance with cep low", {20'd0, q}, 32'h0FF);
        cep = 1'b1;
        step();
        check("R7 carry into upper stages", {20'd0, q}, 32'h100);
        // R8: clear beats load on every stage.
        pe_n = 1'b0; p = 12'hABC;
        step();
        check("R8 chain load all stages", {20'd0, q}, 32'hABC);
        mr_n = 1'b0;
        step();
        check("R8 chain clear all stages", {20'd0, q}, 32'h000);
        // R9 and R1: wrap of the full word.
        mr_n = 1'b1; p = 12'hFFE;
        step();
        pe_n = 1'b1;
        step();
        check("R9 chain at max", {20'd0, q}, 32'hFFF);
        check("R9 chain tc high", {31'd0, tc}, 32'h1);
        cet = 1'b0;
        #1;
        check("R9 chain tc needs cet", {31'd0, tc}, 32'h0);
        cet = 1'b1;
        step();
        check("R1 chain wrap", {20'd0, q}, 32'h000);
        check("R9 chain tc after wrap", {31'd0, tc}, 32'h0);

        // R9: one tc pulse per full sweep.
        tc_hits = 0;
        for (int i = 0; i < 4096; i++) begin
            if (tc) tc_hits++;
            step();
        end
        check("R9 tc pulses per sweep", tc_hits, 32'd1);
        check("R9 sweep returns to zero", {20'd0, q}, 32'h000);

        // Random control sequences on the chain (R7 R8 R9).
        m3 = 12'h000;
        for (int i = 0; i < 3000; i++) begin
            mr_n = ($urandom % 32) != 0;
            pe_n = ($urandom % 16) != 0;
            cep  = ($urandom % 8) != 0;
            cet  = ($urandom % 8) != 0;
            p    = (($urandom % 2) != 0) ? 12'($urandom) : 12'hFF0 | 12'($urandom % 16);
            m3 = ref12(mr_n, pe_n, cep, cet, p, m3);
            step();
            check("R7 random chain q", {20'd0, q}, {20'd0, m3});
            check("R9 random chain tc", {31'd0, tc}, {31'd0, cet && (m3 == 12'hFFF)});
        end

        finish_run();
    end

endmodule